// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block is a small associative store. Each of its rows holds one data word and a valid flag. Software-visible lookups do not use a row number. A search presents a probe word and a column mask, and every row compares its stored word with the probe at the same time. A row reports a match when it is valid and agrees with the probe on every column the mask enables. Columns whose mask bit is clear are ignored for all rows at once.

The per-row results are captured in a registered match vector on the clock edge that accepts the search. At that same edge the block also captures a read-out of the lowest-numbered matching row: its index, its stored word and a hit flag. Rows are loaded through a separate write port that names the row directly. A loaded row becomes valid. The capture registers keep their values until the next search is accepted.

Top module: `masked_cam`

## Requirements
- R1: While reset is asserted and after it is released, `match_vec`, `hit`, `hit_row` and `hit_data` are all zero, and every row is invalid.
- R2: When `wr_en` is high at a clock edge, row `wr_row` stores `wr_data` and becomes valid. A later search returns that word.
- R3: A `search_mask` bit of 0 removes that column from the comparison. A mask bit of 1 requires the stored bit to equal the `search_arg` bit.
- R4: After a search, bit i of `match_vec` is 1 exactly when row i is valid and `((stored_i ^ search_arg) & search_mask) == 0`.
- R5: The results of a search appear one clock edge after `search_en` is sampled high. They stay unchanged on every edge where `search_en` is low, including edges with writes.
- R6: When at least one row matches, `hit` is 1, `hit_row` is the lowest matching index and `hit_data` is that row's stored word.
- R7: When no row matches, `hit` is 0, `hit_row` is 0 and `hit_data` is 0.
- R8: A word written at the same edge that accepts a search does not take part in that search. The search uses the array contents from before that edge.
- R9: An invalid row never matches, even when the mask is all zeros.
- R10: Writing to a row that already holds a word replaces its contents. The old word no longer matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for one row |
| wr_row | input | IDX_W | Row index for the write |
| wr_data | input | WIDTH | Word to store |
| search_en | input | 1 | Search strobe |
| search_arg | input | WIDTH | Probe word |
| search_mask | input | WIDTH | Column enable mask (1 = compare) |
| match_vec | output | WORDS | Registered per-row match result |
| hit | output | 1 | At least one row matched |
| hit_row | output | IDX_W | Lowest matching row index |
| hit_data | output | WIDTH | Stored word of the lowest matching row |

## Verification
Directed searches use three kinds of mask: all ones, all zeros, and a partial mask that hides exactly the columns where the stored word and the probe differ. Together they show that masking is per column and does not mask the whole word. Duplicate words are placed in several rows to check the lowest-index pick. A search is issued at the same edge as a write to its own row, which shows whether the search reads old or new contents. Random traffic probes with the stored words of rows, with random bit flips, under random masks, and it writes between searches. This mixes hits, misses and hold cycles, and each result is compared with a reference model of the array.

// File: rtl/masked_cam_pkg.sv
package masked_cam_pkg;
  // Default geometry of the associative array.
  parameter int unsigned CAM_WORDS_DEF = 8;
  parameter int unsigned CAM_WIDTH_DEF = 16;
  // Depth of the reset release synchronizer.
  parameter int unsigned CAM_RST_STAGES = 2;
endpackage

// File: rtl/cam_rst_sync.sv
module cam_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cam_row.sv
module cam_row #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] cmp_arg,
  input  logic [WIDTH-1:0] cmp_mask,
  output logic [WIDTH-1:0] row_data,
  output logic             row_hit
);
  logic             vld_q, vld_d;
  logic [WIDTH-1:0] word_q, word_d;
  logic [WIDTH-1:0] col_ok;

  // Next state: the valid flag sets on a write, and the word loads under its enable.
  always_comb begin
    vld_d  = vld_q | wr_en;
    word_d = wr_en ? wr_data : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  // Data storage has no reset. A clock enable guards it.
  always_ff @(posedge clk) begin
    if (wr_en) word_q <= word_d;
  end

  // A column agrees when it is masked off or its stored bit equals the probe bit.
  always_comb begin
    col_ok  = (word_q ~^ cmp_arg) | ~cmp_mask;
    row_hit = vld_q & (&col_ok);
  end

  assign row_data = word_q;

  // R9: a row that has never been written cannot report a match
  assert_invalid_no_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> !row_hit);

  // R2: a write leaves the row valid, holding the written word
  assert_write_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (vld_q && row_data == $past(wr_data)));
endmodule

// File: rtl/cam_prio.sv
module cam_prio #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // Scan from the top down so that the lowest requesting index wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  // R6: a reported index always points at a requesting row
  always_comb begin
    if (found) assert_pick_valid_R6: assert (req[idx]);
  end
endmodule

// File: rtl/masked_cam.sv
module masked_cam
  import masked_cam_pkg::*;
#(
  parameter int unsigned WORDS = CAM_WORDS_DEF,
  parameter int unsigned WIDTH = CAM_WIDTH_DEF,
  localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_row,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             search_en,
  input  logic [WIDTH-1:0] search_arg,
  input  logic [WIDTH-1:0] search_mask,
  output logic [WORDS-1:0] match_vec,
  output logic             hit,
  output logic [IDX_W-1:0] hit_row,
  output logic [WIDTH-1:0] hit_data
);
  logic irst_n;

  cam_rst_sync #(.STAGES(CAM_RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (irst_n)
  );

  logic [WORDS-1:0]            row_hit;
  logic [WORDS-1:0][WIDTH-1:0] row_data;

  // One storage and compare slice per row. The compare sees the contents held before the current edge.
  for (genvar r = 0; r < WORDS; r++) begin : g_row
    logic row_we;
    assign row_we = wr_en && (wr_row == IDX_W'(r));
    cam_row #(.WIDTH(WIDTH)) u_row (
      .clk      (clk),
      .rst_n    (irst_n),
      .wr_en    (row_we),
      .wr_data  (wr_data),
      .cmp_arg  (search_arg),
      .cmp_mask (search_mask),
      .row_data (row_data[r]),
      .row_hit  (row_hit[r])
    );
  end

  logic             pick_found;
  logic [IDX_W-1:0] pick_idx;

  cam_prio #(.N(WORDS), .IDX_W(IDX_W)) u_prio (
    .req   (row_hit),
    .found (pick_found),
    .idx   (pick_idx)
  );

  logic [WORDS-1:0] match_q, match_d;
  logic             hit_q, hit_d;
  logic [IDX_W-1:0] row_q, row_d;
  logic [WIDTH-1:0] data_q, data_d;

  // Next state: load on a search strobe and hold otherwise.
  always_comb begin
    match_d = match_q;
    hit_d   = hit_q;
    row_d   = row_q;
    data_d  = data_q;
    if (search_en) begin
      match_d = row_hit;
      hit_d   = pick_found;
      row_d   = pick_idx;
      data_d  = pick_found ? row_data[pick_idx] : '0;
    end
  end

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) begin
      match_q <= '0;
      hit_q   <= 1'b0;
      row_q   <= '0;
      data_q  <= '0;
    end else begin
      match_q <= match_d;
      hit_q   <= hit_d;
      row_q   <= row_d;
      data_q  <= data_d;
    end
  end

  assign match_vec = match_q;
  assign hit       = hit_q;
  assign hit_row   = row_q;
  assign hit_data  = data_q;

  // Rows below the reported index, used by the lowest-match check.
  logic [WORDS-1:0] below_row;
  always_comb begin
    for (int i = 0; i < WORDS; i++) below_row[i] = (IDX_W'(i) < row_q);
  end

  // R5: the results hold on every edge without a search
  assert_hold_R5: assert property (@(posedge clk) disable iff (!irst_n)
    !search_en |=> ($stable(match_vec) && $stable(hit) && $stable(hit_data)));

  // R6: a hit points at the lowest set bit of the match vector
  assert_lowest_R6: assert property (@(posedge clk) disable iff (!irst_n)
    hit |-> (match_vec[hit_row] && ((match_vec & below_row) == '0)));

  // R7: a miss reports a zero index and zero data
  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!irst_n)
    !hit |-> (hit_row == '0 && hit_data == '0));

  // R4: the hit flag agrees with the match vector
  assert_hit_vec_R4: assert property (@(posedge clk) disable iff (!irst_n)
    hit == (match_vec != '0));
endmodule

// File: tb/tb_masked_cam.sv
module tb_masked_cam;
  localparam int unsigned WORDS = 8;
  localparam int unsigned WIDTH = 16;
  localparam int unsigned IDX_W = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             wr_en;
  logic [IDX_W-1:0] wr_row;
  logic [WIDTH-1:0] wr_data;
  logic             search_en;
  logic [WIDTH-1:0] search_arg;
  logic [WIDTH-1:0] search_mask;
  logic [WORDS-1:0] match_vec;
  logic             hit;
  logic [IDX_W-1:0] hit_row;
  logic [WIDTH-1:0] hit_data;

  always #2 clk = ~clk;

  masked_cam #(.WORDS(WORDS), .WIDTH(WIDTH)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
    .search_en(search_en), .search_arg(search_arg), .search_mask(search_mask),
    .match_vec(match_vec), .hit(hit), .hit_row(hit_row), .hit_data(hit_data)
  );

  int tests = 0;
  int fails = 0;

  logic [WIDTH-1:0] mdl [WORDS];
  logic             mvld [WORDS];
  logic [WORDS-1:0] exp_vec;
  logic             exp_hit;
  logic [IDX_W-1:0] exp_row;
  logic [WIDTH-1:0] exp_data;

  function automatic logic [WORDS-1:0] model_match(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] k);
    logic [WORDS-1:0] v;
    for (int i = 0; i < WORDS; i++) v[i] = mvld[i] && (((mdl[i] ^ a) & k) == '0);
    return v;
  endfunction

  task automatic check(input string req);
    tests++;
    if (match_vec !== exp_vec || hit !== exp_hit || hit_row !== exp_row || hit_data !== exp_data) begin
      fails++;
      $display("FAIL %s: vec=%h hit=%0d row=%0d data=%h expected vec=%h hit=%0d row=%0d data=%h",
               req, match_vec, hit, hit_row, hit_data, exp_vec, exp_hit, exp_row, exp_data);
    end
  endtask

  // One clock: drive the inputs, update the model, then check after the edge.
  task automatic cyc(input bit we, input int row, input logic [WIDTH-1:0] d,
                     input bit se, input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] k,
                     input string req);
    wr_en = we; wr_row = row[IDX_W-1:0]; wr_data = d;
    search_en = se; search_arg = a; search_mask = k;
    if (se) begin
      exp_vec = model_match(a, k);
      exp_hit = (exp_vec != '0);
      exp_row = '0; exp_data = '0;
      for (int i = WORDS - 1; i >= 0; i--)
        if (exp_vec[i]) begin exp_row = IDX_W'(i); exp_data = mdl[i]; end
    end
    if (we) begin mdl[row] = d; mvld[row] = 1'b1; end
    @(negedge clk);
    wr_en = 1'b0; search_en = 1'b0;
    check(req);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    for (int i = 0; i < WORDS; i++) begin mdl[i] = '0; mvld[i] = 1'b0; end
    exp_vec = '0; exp_hit = 1'b0; exp_row = '0; exp_data = '0;
    rst_n = 1'b0; wr_en = 1'b0; wr_row = '0; wr_data = '0;
    search_en = 1'b0; search_arg = '0; search_mask = '0;
    repeat (3) @(negedge clk);
    check("R1 during reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after reset");

    // R1/R9: an empty array with an all-zero mask matches nothing
    cyc(0, 0, '0, 1, 16'h0000, 16'h0000, "R9 empty array");

    // R2: write then look up with the full mask
    cyc(1, 2, 16'h00F0, 0, '0, '0, "R5 hold on write");
    cyc(0, 0, '0, 1, 16'h00F0, 16'hFFFF, "R2 stored word found");

    // R3: masked-off differing columns match, included ones do not
    cyc(0, 0, '0, 1, 16'h12F3, 16'h00F0, "R3 partial mask hit");
    cyc(0, 0, '0, 1, 16'h12F3, 16'hFFFF, "R3 full mask miss");
    cyc(0, 0, '0, 1, 16'h12F3, 16'h0000, "R3 zero mask matches valid only");

    // R6: duplicate words, lowest row wins
    cyc(1, 5, 16'hBEEF, 0, '0, '0, "R5 hold");
    cyc(1, 3, 16'hBEEF, 0, '0, '0, "R5 hold");
    cyc(0, 0, '0, 1, 16'hBEEF, 16'hFFFF, "R6 lowest of duplicates");

    // R7: miss clears the read-out
    cyc(0, 0, '0, 1, 16'h0BAD, 16'hFFFF, "R7 miss zero");

    // R8: same-edge write is not seen, then is seen
    cyc(1, 0, 16'hCAFE, 1, 16'hCAFE, 16'hFFFF, "R8 same-edge write unseen");
    cyc(0, 0, '0, 1, 16'hCAFE, 16'hFFFF, "R8 visible next search");

    // R10: overwrite replaces old word
    cyc(1, 0, 16'h1111, 0, '0, '0, "R5 hold");
    cyc(0, 0, '0, 1, 16'hCAFE, 16'hFFFF, "R10 old word gone");
    cyc(0, 0, '0, 1, 16'h1111, 16'hFFFF, "R10 new word found");

    // Random traffic
    for (int n = 0; n < 400; n++) begin
      bit we, se;
      int row, src;
      logic [WIDTH-1:0] d, a, k;
      we  = ($urandom % 2) == 0;
      se  = ($urandom % 3) != 0;
      row = $urandom_range(WORDS - 1);
      d   = WIDTH'($urandom);
      src = $urandom_range(WORDS - 1);
      a   = mdl[src];
      if (($urandom % 2) == 0) a = a ^ (WIDTH'(1) << $urandom_range(WIDTH - 1));
      case ($urandom % 3)
        0: k = '1;
        1: k = '0;
        default: k = WIDTH'($urandom);
      endcase
      cyc(we, row, d, se, a, k, se ? "R4 random search" : "R5 random hold");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule